// File: doc/BRIEF.md
# Product-Term Macrocell Array with Expanders

This block is a configurable sum-of-products logic array of the kind found inside complex programmable logic devices. An AND plane evaluates product terms. Each term can use any input in true or inverted form, plus one feedback column. Every macrocell owns a fixed group of these terms and ORs them together. The macrocell can then invert that sum. It can also capture the result in a register with asynchronous clear and preset and a clock enable, or pass the result straight to its output.

Two mechanisms let a function use more terms than its own group holds:
- **Chain input.** A macrocell can OR in the sum of its own terms from the next-higher macrocell.
- **Shared term.** One product term built from the inputs alone is inverted and offered to every term of the array through an extra column. Using it costs a second pass through the AND plane.

All programming comes from static configuration inputs, one bit per crosspoint. The data inputs and the register controls are plain pins; there is no streaming interface. The block is used by holding a configuration steady, driving `din`, and reading `mc_out`.

Top module: `pal_block`

## Requirements
- R1: A product term is the AND of the literals whose crosspoint bit is set. Column 2n is input n, column 2n+1 is input n inverted, and column 2·N_IN is the shared-term feedback. A term with no crosspoint set evaluates to 1.
- R2: A product term whose off bit is set evaluates to 0, whatever its crosspoints and inputs.
- R3: Macrocell m ORs its N_PT terms. These are rows m·N_PT to m·N_PT+N_PT−1, and crosspoint (row r, column c) is bit r·(2·N_IN+1)+c of `cfg_xpt`.
- R4: With its chain bit set, macrocell m also ORs in the own-term sum of macrocell m+1. The highest macrocell receives a constant 0 on its chain input.
- R5: The shared term uses only the input columns. Its inverse appears in column 2·N_IN of every row, in the same cycle.
- R6: With its invert bit set, a macrocell's sum is complemented before the register and before the bypass path.
- R7: With the bypass bit clear, the output is the register. The register loads the polarity-adjusted sum on a rising clock edge when `clk_en` is 1, and holds it when `clk_en` is 0.
- R8: With the bypass bit set, the output follows the polarity-adjusted sum combinationally.
- R9: `rst_n` low clears every register asynchronously, and it wins over preset. After reset, every registered output reads 0.
- R10: `pre_n` low, with `rst_n` high, sets every register to 1 asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the macrocell registers |
| rst_n | input | 1 | Asynchronous clear, active low, highest priority |
| pre_n | input | 1 | Asynchronous preset, active low |
| clk_en | input | 1 | Register load enable |
| din | input | N_IN | Array inputs |
| cfg_xpt | input | N_PT·N_MC·(2·N_IN+1) | Crosspoint bits of the main rows |
| cfg_pt_off | input | N_PT·N_MC | Per-term force-to-0 bits |
| cfg_sx_xpt | input | 2·N_IN | Crosspoint bits of the shared term |
| cfg_sx_off | input | 1 | Force the shared term to 0 (feedback column then reads 1) |
| cfg_inv | input | N_MC | Per-macrocell output inversion |
| cfg_byp | input | N_MC | Per-macrocell register bypass |
| cfg_pexp | input | N_MC | Per-macrocell chain enable from macrocell m+1 |
| mc_out | output | N_MC | Macrocell outputs |

## Verification
The array holds no state except the macrocell registers, so a fault in the AND plane, the OR grouping, the chain or the shared column shows at `mc_out` in the same cycle on any bypassed macrocell. A fault seen through a registered macrocell appears one edge later. A fault in the register controls shows as a wrong value right after the asynchronous event, or one edge after the enable changes. The bench compares all macrocells against a behavioural model at every clock, across directed settings and random sparse configurations.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef struct packed {
    logic inv;
    logic byp;
    logic pexp;
  } mc_mode_t;

  function automatic int lit_col(input int idx, input bit neg);
    return 2 * idx + (neg ? 1 : 0);
  endfunction
endpackage

// File: rtl/pal_pterm.sv
module pal_pterm #(
  parameter int W = 17
) (
  input  logic [W-1:0] lits,
  input  logic [W-1:0] conn,
  input  logic         off,
  output logic         pt
);
  logic [W-1:0] pass;

  always_comb begin
    for (int c = 0; c < W; c++) pass[c] = ~conn[c] | lits[c];
    pt = ~off & (&pass);
  end
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import pal_pkg::*;
#(
  parameter int N_PT = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pre_n,
  input  logic            en,
  input  logic [N_PT-1:0] pts,
  input  logic            chain_in,
  input  mc_mode_t        mode,
  output logic            own_or,
  output logic            out
);
  logic sum, d, q;

  always_comb begin
    own_or = |pts;
    sum    = own_or | (mode.pexp & chain_in);
    d      = sum ^ mode.inv;
    out    = mode.byp ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n or negedge pre_n) begin
    if (!rst_n)      q <= 1'b0;
    else if (!pre_n) q <= 1'b1;
    else if (en)     q <= d;
  end

  assert_preset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_n |-> q == 1'b1);

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n || !pre_n)
    en |=> q == $past(d));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n || !pre_n)
    !en |=> $stable(q));
endmodule

// File: rtl/pal_block.sv
module pal_block
  import pal_pkg::*;
#(
  parameter int N_IN = 8,
  parameter int N_PT = 5,
  parameter int N_MC = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  pre_n,
  input  logic                                  clk_en,
  input  logic [N_IN-1:0]                       din,
  input  logic [N_PT*N_MC*(2*N_IN+1)-1:0]       cfg_xpt,
  input  logic [N_PT*N_MC-1:0]                  cfg_pt_off,
  input  logic [2*N_IN-1:0]                     cfg_sx_xpt,
  input  logic                                  cfg_sx_off,
  input  logic [N_MC-1:0]                       cfg_inv,
  input  logic [N_MC-1:0]                       cfg_byp,
  input  logic [N_MC-1:0]                       cfg_pexp,
  output logic [N_MC-1:0]                       mc_out
);
  localparam int N_LIT = 2 * N_IN;
  localparam int N_COL = N_LIT + 1;
  localparam int N_ROW = N_PT * N_MC;

  logic [N_LIT-1:0] in_lits;
  logic [N_COL-1:0] row_lits;
  logic             sx_pt;
  logic [N_ROW-1:0] pts;
  logic [N_MC-1:0]  own_or;
  logic [N_MC-1:0]  chain;
  mc_mode_t         mode [N_MC];

  for (genvar n = 0; n < N_IN; n++) begin : g_lit
    assign in_lits[lit_col(n, 1'b0)] = din[n];
    assign in_lits[lit_col(n, 1'b1)] = ~din[n];
  end

  pal_pterm #(.W(N_LIT)) u_shared (
    .lits(in_lits),
    .conn(cfg_sx_xpt),
    .off (cfg_sx_off),
    .pt  (sx_pt)
  );

  assign row_lits = {~sx_pt, in_lits};

  for (genvar r = 0; r < N_ROW; r++) begin : g_row
    pal_pterm #(.W(N_COL)) u_pt (
      .lits(row_lits),
      .conn(cfg_xpt[r*N_COL +: N_COL]),
      .off (cfg_pt_off[r]),
      .pt  (pts[r])
    );
  end

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    if (m == N_MC - 1) begin : g_end
      assign chain[m] = 1'b0;
    end else begin : g_mid
      assign chain[m] = own_or[m+1];
    end

    assign mode[m] = '{inv: cfg_inv[m], byp: cfg_byp[m], pexp: cfg_pexp[m]};

    pal_macrocell #(.N_PT(N_PT)) u_mc (
      .clk     (clk),
      .rst_n   (rst_n),
      .pre_n   (pre_n),
      .en      (clk_en),
      .pts     (pts[m*N_PT +: N_PT]),
      .chain_in(chain[m]),
      .mode    (mode[m]),
      .own_or  (own_or[m]),
      .out     (mc_out[m])
    );

    assert_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_byp[m] && !cfg_inv[m] && !cfg_pexp[m]) |-> mc_out[m] == (|pts[m*N_PT +: N_PT]));

    if (m < N_MC - 1) begin : g_chk
      assert_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_byp[m] && !cfg_inv[m] && cfg_pexp[m] && (|pts[(m+1)*N_PT +: N_PT])) |-> mc_out[m]);
    end
  end
endmodule

// File: tb/pal_block_test.sv
module pal_block_test;
  localparam int N_IN = 8, N_PT = 5, N_MC = 16;
  localparam int N_COL = 2 * N_IN + 1;
  localparam int N_ROW = N_PT * N_MC;

  logic clk = 0, rst_n = 0, pre_n = 1, clk_en = 0;
  logic [N_IN-1:0]        din = '0;
  logic [N_ROW*N_COL-1:0] cfg_xpt = '0;
  logic [N_ROW-1:0]       cfg_pt_off = '1;
  logic [2*N_IN-1:0]      cfg_sx_xpt = '0;
  logic                   cfg_sx_off = 1;
  logic [N_MC-1:0]        cfg_inv = '0, cfg_byp = '0, cfg_pexp = '0;
  logic [N_MC-1:0]        mc_out;

  int checks = 0, fails = 0;
  string cur_req = "R9";
  bit qm [N_MC];
  bit done = 0;

  always #4 clk = ~clk;

  pal_block #(.N_IN(N_IN), .N_PT(N_PT), .N_MC(N_MC)) uut (
    .clk(clk), .rst_n(rst_n), .pre_n(pre_n), .clk_en(clk_en), .din(din),
    .cfg_xpt(cfg_xpt), .cfg_pt_off(cfg_pt_off), .cfg_sx_xpt(cfg_sx_xpt),
    .cfg_sx_off(cfg_sx_off), .cfg_inv(cfg_inv), .cfg_byp(cfg_byp),
    .cfg_pexp(cfg_pexp), .mc_out(mc_out));

  function automatic bit lit_val(int c);
    return (c % 2) ? ~din[c/2] : din[c/2];
  endfunction

  function automatic bit m_fb();
    if (cfg_sx_off) return 1;
    for (int c = 0; c < 2*N_IN; c++)
      if (cfg_sx_xpt[c] && !lit_val(c)) return 1;
    return 0;
  endfunction

  function automatic bit m_term(int r);
    if (cfg_pt_off[r]) return 0;
    for (int c = 0; c < 2*N_IN; c++)
      if (cfg_xpt[r*N_COL + c] && !lit_val(c)) return 0;
    if (cfg_xpt[r*N_COL + 2*N_IN] && !m_fb()) return 0;
    return 1;
  endfunction

  function automatic bit m_own(int m);
    bit s = 0;
    for (int t = 0; t < N_PT; t++) s |= m_term(m*N_PT + t);
    return s;
  endfunction

  function automatic bit m_pol(int m);
    bit s = m_own(m);
    if (cfg_pexp[m] && m < N_MC - 1) s |= m_own(m + 1);
    return s ^ cfg_inv[m];
  endfunction

  always @(posedge clk or negedge rst_n or negedge pre_n) begin
    for (int m = 0; m < N_MC; m++) begin
      if (!rst_n)      qm[m] <= 0;
      else if (!pre_n) qm[m] <= 1;
      else if (clk_en) qm[m] <= m_pol(m);
    end
  end

  function automatic bit m_out(int m);
    return cfg_byp[m] ? m_pol(m) : qm[m];
  endfunction

  always @(negedge clk) if (!done) begin
    for (int m = 0; m < N_MC; m++) begin
      checks++;
      if (mc_out[m] !== m_out(m)) begin
        fails++;
        $display("FAIL %s cycle model mc%0d actual=%b expected=%b", cur_req, m, mc_out[m], m_out(m));
      end
    end
  end

  task automatic expect_bits(string req, logic [N_MC-1:0] act, logic [N_MC-1:0] exp, logic [N_MC-1:0] msk);
    checks++;
    if ((act & msk) !== (exp & msk)) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h mask=%h", req, act, exp, msk);
    end
  endtask

  task automatic set_x(int m, int t, int c);
    cfg_xpt[(m*N_PT + t)*N_COL + c] = 1;
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic rand_cfg();
    for (int b = 0; b < N_ROW*N_COL; b++) cfg_xpt[b] = ($urandom_range(5) == 0);
    for (int r = 0; r < N_ROW; r++) cfg_pt_off[r] = ($urandom_range(3) == 0);
    for (int c = 0; c < 2*N_IN; c++) cfg_sx_xpt[c] = ($urandom_range(4) == 0);
    cfg_sx_off = ($urandom_range(5) == 0);
  endtask

  initial begin
    #(8*100000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    // R9: reset state of registered outputs
    expect_bits("R9", mc_out, '0, '1);
    rst_n = 1;
    step();
    cfg_byp = '1;
    // R1: mc0 term0 = in0 & ~in3 ; mc1 term0 has no crosspoint
    cur_req = "R1";
    set_x(0, 0, 0); set_x(0, 0, 7);
    cfg_pt_off[0] = 0; cfg_pt_off[5] = 0;
    din = 8'b0000_0001; #1;
    expect_bits("R1", mc_out, 16'h0003, 16'h0007);
    din = 8'b0000_1001; #1;
    expect_bits("R1", mc_out, 16'h0002, 16'h0007);
    step();
    // R2: disabling the empty term forces it to 0
    cur_req = "R2";
    cfg_pt_off[5] = 1; #1;
    expect_bits("R2", mc_out, 16'h0000, 16'h0002);
    step();
    // R5: shared term = in1 & in2, mc2 term0 uses feedback column only
    cur_req = "R5";
    cfg_sx_off = 0; cfg_sx_xpt[2] = 1; cfg_sx_xpt[4] = 1;
    set_x(2, 0, 2*N_IN); cfg_pt_off[10] = 0;
    din = 8'b0000_0110; #1;
    expect_bits("R5", mc_out, 16'h0000, 16'h0004);
    din = 8'b0000_0010; #1;
    expect_bits("R5", mc_out, 16'h0004, 16'h0004);
    step();
    // R6: invert mc2
    cur_req = "R6";
    cfg_inv[2] = 1; #1;
    expect_bits("R6", mc_out, 16'h0000, 16'h0004);
    step();
    // R4: mc3 borrows mc4's empty term; mc15 chain gets constant 0
    cur_req = "R4";
    cfg_pexp[3] = 1; cfg_pt_off[4*N_PT] = 0; cfg_pexp[15] = 1; #1;
    expect_bits("R4", mc_out, 16'h0018, 16'h8018);
    step();
    // R3 R8: random combinational configurations
    cur_req = "R3";
    cfg_inv = '0; cfg_pexp = '0;
    for (int k = 0; k < 6; k++) begin
      rand_cfg();
      for (int s = 0; s < 20; s++) begin din = N_IN'($urandom); step(); end
    end
    cur_req = "R8";
    for (int k = 0; k < 6; k++) begin
      rand_cfg();
      cfg_inv = N_MC'($urandom); cfg_pexp = N_MC'($urandom);
      for (int s = 0; s < 20; s++) begin din = N_IN'($urandom); step(); end
    end
    // R7: registered with random enable
    cur_req = "R7";
    cfg_byp = 16'h00FF;
    for (int k = 0; k < 6; k++) begin
      rand_cfg();
      for (int s = 0; s < 30; s++) begin
        din = N_IN'($urandom); clk_en = $urandom_range(1); step();
      end
    end
    cfg_byp = '0; clk_en = 0;
    step(); #1;
    // R10: async preset mid-cycle
    cur_req = "R10";
    pre_n = 0; #1;
    expect_bits("R10", mc_out, '1, '1);
    // R9: clear wins over preset
    cur_req = "R9";
    rst_n = 0; #1;
    expect_bits("R9", mc_out, '0, '1);
    step();
    pre_n = 1; step();
    rst_n = 1; step();
    expect_bits("R9", mc_out, '0, '1);
    clk_en = 1;
    for (int s = 0; s < 20; s++) begin din = N_IN'($urandom); step(); end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule